// File: doc/BRIEF.md
# Multi-Window Shared-Read Cache Loader

This block fills the back buffers of a row of processing elements, each holding a 20x20 window of 8-bit greyscale pixels. Window k of a group sits k columns to the right of window 0, so neighbouring windows share most of their pixels. The image memory returns PIX_RATE adjacent pixels per read. The loader reads each image row across the whole group exactly once. It then hands every read word to all windows that cover those pixels.

Each window needs its own shift of the read stream, from 0 to PIX_RATE-1 pixel positions. That shift is made with one held copy of the previous word and a fixed slice chosen at elaboration from the window's index. No runtime shifter is involved. The controller asserts start with a base row and a word-aligned base column. It waits for done and then asserts swap once the processing elements have taken the filled buffers. Only after swap may the next fill begin, and that fill writes the other bank.

The controller walks through four states. IDLE goes to FILL on start. FILL goes to DRAIN on the cycle the last read is issued. DRAIN goes to FULL when the last write leaves the pipeline. FULL goes back to IDLE on swap, and the bank flips at that point. N_WIN must be a whole multiple of PIX_RATE, and elaboration stops otherwise.

Top module: `mwin_cache_loader`

## Requirements
- R1: After reset, busy_o, done_o, rd_en_o and every wr_en_o bit are low and wr_bank_o is 0.
- R2: A start in IDLE issues one read per cycle, with no gaps, in row-major order. Each of the 20 rows gets WPR = ceil(20/PIX_RATE) + N_WIN/PIX_RATE reads, so a fill totals 20*WPR reads. The address is (base_row+r)*IMG_COLS/PIX_RATE + base_word + w. Word w holds columns w*PIX_RATE to w*PIX_RATE+PIX_RATE-1, with pixel i at bits [8i+7:8i].
- R3: After a fill, window k's cached pixel at row r, column c equals image pixel (base_row+r, base_word*PIX_RATE + k + c).
- R4: Each write carries a row, a group index g and PIX_RATE pixels. The group covers window columns g*PIX_RATE upward, with pixel i at bits [8i+7:8i]. Mask bit i is set exactly when g*PIX_RATE+i < 20. Every window receives exactly 20*ceil(20/PIX_RATE) writes, and its groups ascend within a row.
- R5: A word's writes appear two cycles after its read is issued. Window k's first write comes 2 + floor(k/PIX_RATE) + (k mod PIX_RATE != 0 ? 1 : 0) cycles after the first read.
- R6: done_o rises only after every write of the fill, and no write occurs while done_o is high.
- R7: done_o stays high until swap_i. A start_i while done_o is high causes no read and no write.
- R8: swap_i while done_o is high drops done_o on the next cycle and toggles wr_bank_o. All writes of the following fill carry the new bank.
- R9: busy_o is high during the fill. A start_i during a fill is ignored: the read count and the written data follow the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fill (acted on in IDLE only) |
| swap_i | input | 1 | Back buffer consumed; release it (acted on in FULL only) |
| base_row_i | input | $clog2(IMG_ROWS) | Image row of window row 0 |
| base_word_i | input | $clog2(IMG_COLS/PIX_RATE) | Word index of window 0's left column |
| busy_o | output | 1 | Fill or drain in progress |
| done_o | output | 1 | All windows of the back bank are written |
| rd_en_o | output | 1 | Image read request |
| rd_addr_o | output | $clog2(IMG_COLS/PIX_RATE*IMG_ROWS) | Image word address |
| rd_data_i | input | PIX_RATE*8 | Image word, one cycle after the request |
| wr_bank_o | output | 1 | Bank being written in every cache |
| wr_en_o | output | N_WIN | Write strobe per window |
| wr_row_o | output | N_WIN*$clog2(21) | Window row per window |
| wr_grp_o | output | N_WIN*$clog2(GRPS+1) | Column group per window |
| wr_data_o | output | N_WIN*PIX_RATE*8 | Aligned pixels per window |
| wr_mask_o | output | N_WIN*PIX_RATE | Valid pixels of the group per window |

## Verification
A wrong alignment slice or a stale held word shows up first as a cached pixel that differs from the image slice. That error is visible two cycles after the offending read, and at the latest when the scoreboard compares on done. A counter that skips or repeats a word shifts the read count away from 20*WPR. It also moves a window's first write off its predicted cycle, so the fault appears within the first image row. A controller stuck in the wrong state shows as done rising early with writes still pending, as a late start being honoured, or as a bank that does not flip on swap.

// File: rtl/mwl_pkg.sv
package mwl_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FILL  = 2'd1,
        LD_DRAIN = 2'd2,
        LD_FULL  = 2'd3
    } ld_state_e;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/mwl_addr_seq.sv
module mwl_addr_seq #(
    parameter int WIN       = 20,
    parameter int WPR       = 12,
    parameter int IMG_WORDS = 32,
    parameter int ADDR_W    = 11,
    parameter int ROW_W     = 6,
    parameter int BW_W      = 5,
    parameter int RI_W      = 5,
    parameter int WW_W      = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic [ROW_W-1:0]  base_row_i,
    input  logic [BW_W-1:0]   base_word_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [RI_W-1:0]   row_o,
    output logic [WW_W-1:0]   word_o,
    output logic              last_o
);

    logic [ROW_W-1:0] base_row_q;
    logic [BW_W-1:0]  base_word_q;
    logic [RI_W-1:0]  row_q;
    logic [WW_W-1:0]  word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            base_row_q  <= '0;
            base_word_q <= '0;
            row_q       <= '0;
            word_q      <= '0;
        end else if (clr_i) begin
            base_row_q  <= base_row_i;
            base_word_q <= base_word_i;
            row_q       <= '0;
            word_q      <= '0;
        end else if (run_i) begin
            if (word_q == WW_W'(WPR - 1)) begin
                word_q <= '0;
                row_q  <= row_q + 1'b1;
            end else begin
                word_q <= word_q + 1'b1;
            end
        end
    end

    always_comb begin
        addr_o = ADDR_W'((int'(base_row_q) + int'(row_q)) * IMG_WORDS
                         + int'(base_word_q) + int'(word_q));
        row_o  = row_q;
        word_o = word_q;
        last_o = (row_q == RI_W'(WIN - 1)) && (word_q == WW_W'(WPR - 1));
    end

    // R2: within a row, consecutive reads step the address by one word
    a_r2_addr_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && (word_q != '0) |-> addr_o == $past(addr_o) + 1'b1);

endmodule

// File: rtl/mwl_lane.sv
module mwl_lane #(
    parameter int K        = 0,
    parameter int PIX_RATE = 2,
    parameter int WIN      = 20,
    parameter int PIX_W    = 8,
    parameter int RI_W     = 5,
    parameter int WW_W     = 4,
    parameter int G_W      = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      in_vld_i,
    input  logic [RI_W-1:0]           in_row_i,
    input  logic [WW_W-1:0]           in_word_i,
    input  logic [PIX_RATE*PIX_W-1:0] aligned_i,
    output logic                      wr_en_o,
    output logic [RI_W-1:0]           wr_row_o,
    output logic [G_W-1:0]            wr_grp_o,
    output logic [PIX_RATE*PIX_W-1:0] wr_data_o,
    output logic [PIX_RATE-1:0]       wr_mask_o
);

    localparam int OFS  = K % PIX_RATE;
    localparam int LEAD = K / PIX_RATE;
    localparam int SKEW = LEAD + ((OFS != 0) ? 1 : 0);
    localparam int GRPS = mwl_pkg::ceil_div(WIN, PIX_RATE);

    int                  grp_i;
    logic                hit;
    logic [PIX_RATE-1:0] mask_c;

    always_comb begin
        grp_i = int'(in_word_i) - SKEW;
        hit   = in_vld_i && (grp_i >= 0) && (grp_i < GRPS);
        for (int i = 0; i < PIX_RATE; i++) begin
            mask_c[i] = (grp_i * PIX_RATE + i) < WIN;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_en_o   <= 1'b0;
            wr_row_o  <= '0;
            wr_grp_o  <= '0;
            wr_data_o <= '0;
            wr_mask_o <= '0;
        end else begin
            wr_en_o <= hit;
            if (hit) begin
                wr_row_o  <= in_row_i;
                wr_grp_o  <= G_W'(grp_i);
                wr_data_o <= aligned_i;
                wr_mask_o <= mask_c;
            end
        end
    end

    // R4: within a row a window's groups arrive back to back in ascending order
    a_r4_grp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o && (wr_grp_o != G_W'(GRPS - 1))
        |=> wr_en_o && (wr_grp_o == $past(wr_grp_o) + 1'b1));

    // R4: a write never carries an empty mask
    a_r4_mask_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> wr_mask_o[0]);

endmodule

// File: rtl/mwin_cache_loader.sv
module mwin_cache_loader #(
    parameter int PIX_W    = 8,
    parameter int WIN      = 20,
    parameter int PIX_RATE = 2,
    parameter int N_WIN    = 4,
    parameter int IMG_COLS = 64,
    parameter int IMG_ROWS = 48,
    localparam int IMG_WORDS = IMG_COLS / PIX_RATE,
    localparam int GRPS      = (WIN + PIX_RATE - 1) / PIX_RATE,
    localparam int WORD_W    = PIX_RATE * PIX_W,
    localparam int ADDR_W    = $clog2(IMG_WORDS * IMG_ROWS),
    localparam int ROW_W     = $clog2(IMG_ROWS),
    localparam int BW_W      = $clog2(IMG_WORDS),
    localparam int RI_W      = $clog2(WIN + 1),
    localparam int G_W       = $clog2(GRPS + 1)
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       start_i,
    input  logic                       swap_i,
    input  logic [ROW_W-1:0]           base_row_i,
    input  logic [BW_W-1:0]            base_word_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       rd_en_o,
    output logic [ADDR_W-1:0]          rd_addr_o,
    input  logic [WORD_W-1:0]          rd_data_i,
    output logic                       wr_bank_o,
    output logic [N_WIN-1:0]           wr_en_o,
    output logic [N_WIN*RI_W-1:0]      wr_row_o,
    output logic [N_WIN*G_W-1:0]       wr_grp_o,
    output logic [N_WIN*WORD_W-1:0]    wr_data_o,
    output logic [N_WIN*PIX_RATE-1:0]  wr_mask_o
);
    import mwl_pkg::*;

    localparam int WPR    = GRPS + N_WIN / PIX_RATE;
    localparam int WW_W   = $clog2(WPR + 1);
    localparam int HOLD_W = (PIX_RATE > 1) ? (PIX_RATE - 1) * PIX_W : 1;

    if ((N_WIN % PIX_RATE) != 0) begin : g_bad_cfg
        $error("N_WIN must be a multiple of PIX_RATE");
    end

    ld_state_e state_q, state_d;

    logic              run, clr;
    logic              seq_last;
    logic [RI_W-1:0]   seq_row;
    logic [WW_W-1:0]   seq_word;
    logic              s1_vld_q, s1_last_q, w_last_q;
    logic [RI_W-1:0]   s1_row_q;
    logic [WW_W-1:0]   s1_word_q;
    logic [HOLD_W-1:0] hold_q;
    logic [WORD_W+HOLD_W-1:0] pair;
    logic              bank_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= LD_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (start_i)           state_d = LD_FILL;
            LD_FILL:  if (seq_last)          state_d = LD_DRAIN;
            LD_DRAIN: if (w_last_q)          state_d = LD_FULL;
            LD_FULL:  if (swap_i)            state_d = LD_IDLE;
            default:                         state_d = LD_IDLE;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        run    = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        clr    = 1'b0;
        unique case (state_q)
            LD_IDLE:  clr = start_i;
            LD_FILL:  begin run = 1'b1; busy_o = 1'b1; end
            LD_DRAIN: busy_o = 1'b1;
            LD_FULL:  done_o = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                bank_q <= 1'b0;
        else if ((state_q == LD_FULL) && swap_i)    bank_q <= ~bank_q;
    end
    assign wr_bank_o = bank_q;

    // ---------------- read address sequencing ----------------
    mwl_addr_seq #(
        .WIN(WIN), .WPR(WPR), .IMG_WORDS(IMG_WORDS), .ADDR_W(ADDR_W),
        .ROW_W(ROW_W), .BW_W(BW_W), .RI_W(RI_W), .WW_W(WW_W)
    ) u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .run_i(run),
        .base_row_i(base_row_i), .base_word_i(base_word_i),
        .addr_o(rd_addr_o), .row_o(seq_row), .word_o(seq_word),
        .last_o(seq_last)
    );
    assign rd_en_o = run;

    // ---------------- data-return stage and held word ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_vld_q  <= 1'b0;
            s1_last_q <= 1'b0;
            w_last_q  <= 1'b0;
            s1_row_q  <= '0;
            s1_word_q <= '0;
            hold_q    <= '0;
        end else begin
            s1_vld_q  <= run;
            s1_last_q <= run && seq_last;
            w_last_q  <= s1_last_q;
            s1_row_q  <= seq_row;
            s1_word_q <= seq_word;
            if (s1_vld_q) hold_q <= rd_data_i[WORD_W-1 -: HOLD_W];
        end
    end
    assign pair = {rd_data_i, hold_q};

    // ---------------- per-window alignment and write lanes ----------------
    for (genvar k = 0; k < N_WIN; k++) begin : g_win
        localparam int OFS = k % PIX_RATE;
        logic [WORD_W-1:0] aligned;
        if (OFS == 0) begin : g_direct
            assign aligned = rd_data_i;
        end else begin : g_shift
            assign aligned = pair[(OFS - 1) * PIX_W +: WORD_W];
        end

        mwl_lane #(
            .K(k), .PIX_RATE(PIX_RATE), .WIN(WIN), .PIX_W(PIX_W),
            .RI_W(RI_W), .WW_W(WW_W), .G_W(G_W)
        ) u_lane (
            .clk_i(clk_i), .rst_ni(rst_ni),
            .in_vld_i(s1_vld_q), .in_row_i(s1_row_q), .in_word_i(s1_word_q),
            .aligned_i(aligned),
            .wr_en_o(wr_en_o[k]),
            .wr_row_o(wr_row_o[k*RI_W +: RI_W]),
            .wr_grp_o(wr_grp_o[k*G_W +: G_W]),
            .wr_data_o(wr_data_o[k*WORD_W +: WORD_W]),
            .wr_mask_o(wr_mask_o[k*PIX_RATE +: PIX_RATE])
        );
    end

    // R6: the finished bank is never written while done is shown
    a_r6_quiet_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (wr_en_o == '0));

    // R7: done holds until swap
    a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !swap_i |=> done_o);

    // R7: a start while full starts no reads
    a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && start_i && !swap_i |=> !rd_en_o);

    // R8: swap releases the buffer and flips the bank
    a_r8_swap_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && swap_i |=> !done_o && (wr_bank_o != $past(wr_bank_o)));

    // R9: reads only while busy
    a_r9_read_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_en_o) |-> busy_o && !done_o);

endmodule

// File: tb/mwin_cache_loader_tb_top.sv
`timescale 1ns/1ps
module mwin_cache_loader_tb_top;

    localparam int PW = 8, WIN = 20, P = 8, N = 16, IMG_COLS = 64, IMG_ROWS = 48;
    localparam int IMG_WORDS = IMG_COLS / P;
    localparam int GRPS = (WIN + P - 1) / P;
    localparam int WPR = GRPS + N / P;
    localparam int WW = P * PW;
    localparam int ADDR_W = $clog2(IMG_WORDS * IMG_ROWS);
    localparam int ROW_W = $clog2(IMG_ROWS);
    localparam int BW_W = $clog2(IMG_WORDS);
    localparam int RI_W = $clog2(WIN + 1);
    localparam int G_W = $clog2(GRPS + 1);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, swap = 1'b0;
    logic [ROW_W-1:0] base_row = '0;
    logic [BW_W-1:0]  base_word = '0;
    logic busy, done, rd_en, wr_bank;
    logic [ADDR_W-1:0] rd_addr;
    logic [WW-1:0] rd_data = '0;
    logic [N-1:0] wr_en;
    logic [N*RI_W-1:0] wr_row;
    logic [N*G_W-1:0] wr_grp;
    logic [N*WW-1:0] wr_data;
    logic [N*P-1:0] wr_mask;

    always #2.5 clk = ~clk;

    mwin_cache_loader #(.PIX_W(PW), .WIN(WIN), .PIX_RATE(P), .N_WIN(N),
        .IMG_COLS(IMG_COLS), .IMG_ROWS(IMG_ROWS)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .swap_i(swap),
        .base_row_i(base_row), .base_word_i(base_word), .busy_o(busy),
        .done_o(done), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_bank_o(wr_bank), .wr_en_o(wr_en), .wr_row_o(wr_row), .wr_grp_o(wr_grp),
        .wr_data_o(wr_data), .wr_mask_o(wr_mask));

    function automatic logic [7:0] pix(input int r, input int c);
        return 8'((r * 29 + c * 13 + ((r * c) >> 2) + 7) & 255);
    endfunction

    // image memory model, one-cycle read latency
    always @(posedge clk) begin
        if (rd_en) begin
            for (int i = 0; i < P; i++)
                rd_data[i*PW +: PW] <= pix(int'(rd_addr) / IMG_WORDS,
                                           (int'(rd_addr) % IMG_WORDS) * P + i);
        end
    end

    typedef struct { int k; int r; int c; logic [7:0] v; } exp_t;
    exp_t sb_q[$];

    int n_cmp = 0, n_bad = 0;
    int cyc = 0, rd_cnt = 0, first_rd = -1, post_done_wr = 0;
    int wr_cnt [N];
    logic exp_bank = 1'b0;
    logic done_prev = 1'b0;
    logic [WIN*PW-1:0] cache [N][WIN];

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: capture writes, compare against scoreboard when done rises
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en) begin
                rd_cnt++;
                if (first_rd < 0) first_rd = cyc;
            end
            for (int k = 0; k < N; k++) begin
                if (wr_en[k]) begin
                    int r, g;
                    r = int'(wr_row[k*RI_W +: RI_W]);
                    g = int'(wr_grp[k*G_W +: G_W]);
                    wr_cnt[k]++;
                    if (done) post_done_wr++;
                    if (wr_bank != exp_bank) chk("R8 bank", int'(wr_bank), int'(exp_bank));
                    if (wr_cnt[k] == 1)   // R5 first-write latency
                        chk("R5 first write cycle", cyc,
                            first_rd + 2 + k / P + ((k % P != 0) ? 1 : 0));
                    for (int i = 0; i < P; i++) begin
                        if (wr_mask[k*P+i] != ((g * P + i) < WIN))
                            chk("R4 mask", int'(wr_mask[k*P+i]), int'((g * P + i) < WIN));
                        if (wr_mask[k*P+i] && r < WIN)
                            cache[k][r][(g*P+i)*PW +: PW] = wr_data[k*WW + i*PW +: PW];
                    end
                end
            end
            if (done && !done_prev) begin
                while (sb_q.size() > 0) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk($sformatf("R3 win%0d r%0d c%0d", e.k, e.r, e.c),
                        int'(cache[e.k][e.r][e.c*PW +: PW]), int'(e.v));
                end
            end
            done_prev = done;
        end
    end

    task automatic wait_done();
        int t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        if (!done) chk("watchdog done", 0, 1);
    endtask

    // driver: push expected pixels, then request the fill
    task automatic load(input int br, input int bw, input logic bank);
        rd_cnt = 0; first_rd = -1; post_done_wr = 0; exp_bank = bank;
        for (int k = 0; k < N; k++) wr_cnt[k] = 0;
        for (int k = 0; k < N; k++)
            for (int r = 0; r < WIN; r++)
                for (int c = 0; c < WIN; c++)
                    sb_q.push_back('{k, r, c, pix(br + r, bw * P + k + c)});
        @(negedge clk);
        base_row = ROW_W'(br); base_word = BW_W'(bw); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start", int'(busy), 1);
        repeat (3) @(negedge clk);
        // R9: a second start mid-fill with another base must be ignored
        base_row = ROW_W'(2); base_word = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);
        chk("R2 reads per fill", rd_cnt, WIN * WPR);
        for (int k = 0; k < N; k++) chk("R4 writes per window", wr_cnt[k], WIN * GRPS);
        chk("R6 done holds", int'(done), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 done", int'(done), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 rd_en", int'(rd_en), 0);
        chk("R1 wr_en", int'(wr_en), 0);
        chk("R1 bank", int'(wr_bank), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        load(3, 1, 1'b0);

        // R7: start while full does nothing
        begin
            int rd_before;
            rd_before = rd_cnt;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (8) @(negedge clk);
            chk("R7 no reads while full", rd_cnt - rd_before, 0);
            chk("R7 done still high", int'(done), 1);
            chk("R6 no writes after done", post_done_wr, 0);
        end

        // R8: swap releases and flips the bank
        swap = 1'b1;
        @(negedge clk);
        swap = 1'b0;
        chk("R8 done dropped", int'(done), 0);
        chk("R8 bank flipped", int'(wr_bank), 1);

        load(25, 3, 1'b1);
        repeat (4) @(negedge clk);
        chk("R6 no writes after done", post_done_wr, 0);
        swap = 1'b1;
        @(negedge clk);
        swap = 1'b0;
        chk("R8 bank back", int'(wr_bank), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule